// File: doc/BRIEF.md
# Double-Width Compare-And-Swap Unit

This block sits beside a small on-chip word memory and carries out atomic updates for several requesters. Each requester can issue one of four operations: a plain read, a plain write, a single-word compare-and-swap, or a double-word compare-and-swap. The double-word form treats an even/odd pair of words as one record: a version counter in the even word and a pointer in the odd word. The pair is replaced only when both halves equal the values the requester expects.

A round-robin arbiter picks at most one request per cycle. The chosen request is compared and written in that same cycle, so no other requester can slip in between the compare and the write. Plain writes take the same path, which places them in a single order with the atomic operations. One cycle after the grant, the unit returns a response. The response holds a success flag, an error flag and the old stored words, so a requester that loses can retry from the returned values without issuing another read.

Requesters keep their request asserted until they see their grant bit. Operation codes are: 2'b00 read, 2'b01 write, 2'b10 single-word swap, 2'b11 double-word swap.

Top module: `dwcas_unit`

## Requirements
- R1: `grant` is one-hot or zero, and only a requester with `req_valid` set is granted. The search starts at requester 0 after reset and, after each grant, at the index just above the last winner, wrapping around. A grant is given whenever any request is pending.
- R2: `rsp_valid` rises exactly one cycle after a grant, and `rsp_id` carries the granted index. `rsp_valid` is low in any cycle that follows a cycle with no grant.
- R3: A read (op 2'b00) returns the word at `addr` in `rsp_old_lo` and the word at `addr|1` in `rsp_old_hi`. It reports ok=1 and err=0 and changes no memory.
- R4: A write (op 2'b01) stores `req_new_lo` at `addr` and reports ok=1. The response carries the word held before the write.
- R5: A single-word swap (op 2'b10) writes `req_new_lo` at `addr` only if the word there equals `req_cmp_lo`. ok reports whether it did. The old word is returned either way.
- R6: A double-word swap (op 2'b11) compares the counter at the even `addr` with `req_cmp_lo` and the pointer at `addr+1` with `req_cmp_hi`. Only when both match does it write `req_new_lo` and `req_new_hi` into those two words. On any mismatch neither word changes and ok=0. Both old words are returned in every case.
- R7: A double-word swap with an odd `addr` reports err=1 and ok=0, and modifies nothing.
- R8: A double-word swap whose new counter equals its expected counter reports err=1 and ok=0, and modifies nothing, because every accepted update must change the version.
- R9: When several requesters present double-word swaps on the same pair with the same expected values in the same cycle, exactly one succeeds. Each loser receives the pair the winner wrote.
- R10: After reset every memory word reads zero, `grant` is zero and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Request pending, one bit per requester |
| req_op | input | N_REQ x 2 | Operation code per requester |
| req_addr | input | N_REQ x AW | Word address per requester |
| req_cmp_lo | input | N_REQ x DW | Expected word, or expected counter |
| req_cmp_hi | input | N_REQ x DW | Expected pointer (double-word only) |
| req_new_lo | input | N_REQ x DW | Write data, or new counter |
| req_new_hi | input | N_REQ x DW | New pointer (double-word only) |
| grant | output | N_REQ | One-hot grant, same cycle as the request |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | IW | Index of the requester served |
| rsp_ok | output | 1 | Operation took effect |
| rsp_err | output | 1 | Request rejected as malformed |
| rsp_old_lo | output | DW | Word at addr before the operation |
| rsp_old_hi | output | DW | Word at addr\|1 before the operation |

## Verification
A wrong rotation pointer shows on `grant` in the first cycle where two or more requesters contend. A wrong stored word shows in `rsp_old_lo`/`rsp_old_hi` the next time any requester touches that address. It also flips the ok flag of a swap expecting the true value, one cycle after that swap's grant. The bench keeps a behavioural memory and a rotation pointer of its own and compares the grant and the full response every cycle. This catches a divergence within one cycle of the first access that exposes it. A closing sweep reads every word.

// File: rtl/dwcas_pkg.sv
package dwcas_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_CAS1  = 2'b10,
    OP_CAS2  = 2'b11
  } op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  // next-state: first requester at or after the pointer, wrapping
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!gnt_any && req[(int'(ptr_q) + k) % N]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'((int'(ptr_q) + k) % N);
        gnt[(int'(ptr_q) + k) % N] = 1'b1;
      end
    end
    ptr_en = gnt_any;
    ptr_d  = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_to_requester_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_no_idle_with_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_lo,
  input  logic [AW-1:0] addr_hi,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [DW-1:0] wd_lo,
  input  logic [DW-1:0] wd_hi,
  output logic [DW-1:0] rd_lo,
  output logic [DW-1:0] rd_hi
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q, mem_d;
  logic                     mem_en;

  assign rd_lo = mem_q[addr_lo];
  assign rd_hi = mem_q[addr_hi];

  always_comb begin
    mem_d  = mem_q;
    mem_en = we_lo | we_hi;
    if (we_lo) mem_d[addr_lo] = wd_lo;
    if (we_hi) mem_d[addr_hi] = wd_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  // a cycle without a write enable must leave every word untouched
  p_hold_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_lo && !we_hi) |=> $stable(mem_q));
endmodule

// File: rtl/cas_exec.sv
module cas_exec
  import dwcas_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] cmp_lo,
  input  logic [DW-1:0] cmp_hi,
  input  logic [DW-1:0] new_lo,
  input  logic [DW-1:0] old_lo,
  input  logic [DW-1:0] old_hi,
  input  logic          active,
  output logic          we_lo,
  output logic          we_hi,
  output logic          ok,
  output logic          err
);
  logic lo_match, hi_match;

  assign lo_match = (old_lo == cmp_lo);
  assign hi_match = (old_hi == cmp_hi);

  always_comb begin
    we_lo = 1'b0;
    we_hi = 1'b0;
    ok    = 1'b0;
    err   = 1'b0;
    unique case (op)
      OP_READ:  ok = 1'b1;
      OP_WRITE: begin ok = 1'b1; we_lo = active; end
      OP_CAS1:  begin ok = lo_match; we_lo = active & lo_match; end
      OP_CAS2: begin
        err = addr[0] | (new_lo == cmp_lo);
        ok  = !err && lo_match && hi_match;
        we_lo = active & ok;
        we_hi = active & ok;
      end
    endcase
  end
endmodule

// File: rtl/dwcas_unit.sv
module dwcas_unit
  import dwcas_pkg::*;
#(
  parameter int N_REQ = 3,
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_REQ-1:0]           req_valid,
  input  logic [N_REQ-1:0][1:0]      req_op,
  input  logic [N_REQ-1:0][AW-1:0]   req_addr,
  input  logic [N_REQ-1:0][DW-1:0]   req_cmp_lo,
  input  logic [N_REQ-1:0][DW-1:0]   req_cmp_hi,
  input  logic [N_REQ-1:0][DW-1:0]   req_new_lo,
  input  logic [N_REQ-1:0][DW-1:0]   req_new_hi,
  output logic [N_REQ-1:0]           grant,
  output logic                       rsp_valid,
  output logic [IW-1:0]              rsp_id,
  output logic                       rsp_ok,
  output logic                       rsp_err,
  output logic [DW-1:0]              rsp_old_lo,
  output logic [DW-1:0]              rsp_old_hi
);
  logic [IW-1:0] gnt_idx;
  logic          gnt_any;
  op_e           sel_op;
  logic [AW-1:0] sel_addr, sel_addr_hi;
  logic [DW-1:0] old_lo, old_hi;
  logic          we_lo, we_hi, ex_ok, ex_err;

  rr_arbiter #(.N(N_REQ), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(grant), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  assign sel_op      = op_e'(req_op[gnt_idx]);
  assign sel_addr    = req_addr[gnt_idx];
  assign sel_addr_hi = sel_addr | AW'(1);

  word_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .addr_lo(sel_addr), .addr_hi(sel_addr_hi),
    .we_lo(we_lo), .we_hi(we_hi),
    .wd_lo(req_new_lo[gnt_idx]), .wd_hi(req_new_hi[gnt_idx]),
    .rd_lo(old_lo), .rd_hi(old_hi)
  );

  cas_exec #(.DW(DW), .AW(AW)) u_exec (
    .op(sel_op), .addr(sel_addr),
    .cmp_lo(req_cmp_lo[gnt_idx]), .cmp_hi(req_cmp_hi[gnt_idx]),
    .new_lo(req_new_lo[gnt_idx]),
    .old_lo(old_lo), .old_hi(old_hi), .active(gnt_any),
    .we_lo(we_lo), .we_hi(we_hi), .ok(ex_ok), .err(ex_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= gnt_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_id     <= '0;
      rsp_ok     <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_old_lo <= '0;
      rsp_old_hi <= '0;
    end else if (gnt_any) begin
      rsp_id     <= gnt_idx;
      rsp_ok     <= ex_ok;
      rsp_err    <= ex_err;
      rsp_old_lo <= old_lo;
      rsp_old_hi <= old_hi;
    end
  end

  p_rsp_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> rsp_valid);
  p_no_rsp_without_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !rsp_valid);
  p_ok_err_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_ok && rsp_err));
  p_err_writes_nothing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_err |-> !(we_lo || we_hi));
endmodule

// File: tb/dwcas_unit_bench.sv
module dwcas_unit_bench;
  localparam int N  = 3;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk, rst_n;
  logic [N-1:0]          rv;
  logic [N-1:0][1:0]     rop;
  logic [N-1:0][AW-1:0]  raddr;
  logic [N-1:0][DW-1:0]  rcl, rch, rnl, rnh;
  logic [N-1:0]          grant;
  logic                  rsp_valid, rsp_ok, rsp_err;
  logic [IW-1:0]         rsp_id;
  logic [DW-1:0]         rsp_old_lo, rsp_old_hi;

  dwcas_unit #(.N_REQ(N), .DW(DW), .AW(AW), .IW(IW)) u_dwcas_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_op(rop), .req_addr(raddr),
    .req_cmp_lo(rcl), .req_cmp_hi(rch), .req_new_lo(rnl), .req_new_hi(rnh),
    .grant(grant), .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_ok(rsp_ok),
    .rsp_err(rsp_err), .rsp_old_lo(rsp_old_lo), .rsp_old_hi(rsp_old_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0, cycles = 0;
  logic [DW-1:0] mm [DEPTH];
  int  mptr;
  bit  e_v, e_ok, e_err;
  int  e_id, e_op;
  logic [DW-1:0] e_lo, e_hi;
  int  succ_cnt;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit good, string req, string msg);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic put(int i, int op, int a, logic [DW-1:0] cl, logic [DW-1:0] ch,
                     logic [DW-1:0] nl, logic [DW-1:0] nh);
    rv[i] = 1'b1; rop[i] = 2'(op); raddr[i] = AW'(a);
    rcl[i] = cl; rch[i] = ch; rnl[i] = nl; rnh[i] = nh;
  endtask

  // one clock: model grant and response, check both
  task automatic tick();
    int g;
    logic [N-1:0] eg;
    logic [AW-1:0] a, ah;
    bit match;
    string tag;
    #1;
    g = -1;
    for (int k = 0; k < N; k++)
      if (g < 0 && rv[(mptr + k) % N]) g = (mptr + k) % N;
    eg = (g >= 0) ? N'(1 << g) : '0;
    chk(grant == eg, "R1", $sformatf("grant act %b exp %b", grant, eg));
    e_v = (g >= 0);
    if (e_v) begin
      a = raddr[g]; ah = a | AW'(1);
      e_id = g; e_op = int'(rop[g]);
      e_lo = mm[a]; e_hi = mm[ah];
      e_ok = 1'b0; e_err = 1'b0;
      case (e_op)
        0: e_ok = 1'b1;
        1: begin e_ok = 1'b1; mm[a] = rnl[g]; end
        2: begin e_ok = (mm[a] == rcl[g]); if (e_ok) mm[a] = rnl[g]; end
        default: begin
          e_err = a[0] || (rnl[g] == rcl[g]);
          match = (mm[a] == rcl[g]) && (mm[ah] == rch[g]);
          e_ok  = !e_err && match;
          if (e_ok) begin mm[a] = rnl[g]; mm[ah] = rnh[g]; end
        end
      endcase
      mptr = (g + 1) % N;
    end
    @(posedge clk);
    @(negedge clk);
    if (e_v) begin
      tag = (e_op == 0) ? "R3" : (e_op == 1) ? "R4" : (e_op == 2) ? "R5" :
            (e_err ? (raddr[g][0] ? "R7" : "R8") : "R6");
      chk(rsp_valid && int'(rsp_id) == e_id, "R2",
          $sformatf("valid/id act %b/%0d exp 1/%0d", rsp_valid, rsp_id, e_id));
      chk(rsp_ok == e_ok && rsp_err == e_err && rsp_old_lo == e_lo && rsp_old_hi == e_hi,
          tag, $sformatf("ok/err/lo/hi act %b/%b/%h/%h exp %b/%b/%h/%h",
          rsp_ok, rsp_err, rsp_old_lo, rsp_old_hi, e_ok, e_err, e_lo, e_hi));
      if (e_op == 3 && rsp_ok) succ_cnt++;
      rv[g] = 1'b0;
    end else begin
      chk(!rsp_valid, "R2", $sformatf("rsp_valid act %b exp 0", rsp_valid));
    end
  endtask

  task automatic drain();
    while (|rv) tick();
  endtask

  initial begin
    rv = '0; rop = '0; raddr = '0; rcl = '0; rch = '0; rnl = '0; rnh = '0;
    for (int i = 0; i < DEPTH; i++) mm[i] = '0;
    mptr = 0; succ_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state at the ports
    chk(!rsp_valid && grant == '0, "R10",
        $sformatf("valid/grant act %b/%b exp 0/0", rsp_valid, grant));
    rst_n = 1'b1;
    @(negedge clk);
    tick();
    put(0, 0, 0, 0, 0, 0, 0); drain();     // R10 memory zero, R3 read
    put(1, 0, 6, 0, 0, 0, 0); drain();

    // R1 R4: all three write at once, rotation order
    put(0, 1, 2, 0, 0, 32'h11, 0);
    put(1, 1, 3, 0, 0, 32'h22, 0);
    put(2, 1, 4, 0, 0, 32'h33, 0);
    drain();
    put(2, 0, 2, 0, 0, 0, 0); drain();     // R3 pair read 2/3

    // R5 single-word swap: hit then miss
    put(1, 2, 4, 32'h33, 0, 32'h44, 0); drain();
    put(0, 2, 4, 32'h33, 0, 32'h55, 0); drain();

    // R6 double-word swap on pair 2/3 (counter 0x11, pointer 0x22)
    put(0, 3, 2, 32'h11, 32'h22, 32'h12, 32'hA0); drain();
    put(1, 3, 2, 32'h11, 32'hA0, 32'h13, 32'hB0); drain(); // stale counter
    put(2, 3, 2, 32'h12, 32'h22, 32'h13, 32'hB0); drain(); // stale pointer
    put(0, 3, 3, 32'hA0, 32'h0,  32'h99, 32'h1);  drain(); // R7 odd address
    put(1, 3, 2, 32'h12, 32'hA0, 32'h12, 32'hC0); drain(); // R8 same counter
    put(2, 0, 2, 0, 0, 0, 0); drain();                     // pair unchanged

    // R9: three writers race with identical expected pair
    succ_cnt = 0;
    put(0, 3, 8, 0, 0, 32'h1, 32'hD0);
    put(1, 3, 8, 0, 0, 32'h2, 32'hD1);
    put(2, 3, 8, 0, 0, 32'h3, 32'hD2);
    drain();
    chk(succ_cnt == 1, "R9", $sformatf("winners act %0d exp 1", succ_cnt));

    // mixed traffic on few addresses to force collisions
    for (int it = 0; it < 300; it++) begin
      for (int i = 0; i < N; i++) begin
        if (!rv[i] && ($urandom % 3 != 0)) begin
          int a;
          a = int'($urandom % 6);
          put(i, int'($urandom % 4), a, DW'($urandom % 3), DW'($urandom % 3),
              DW'($urandom % 4), DW'($urandom % 4));
        end
      end
      tick();
    end
    drain();

    // closing sweep: R3 reads of every word
    for (int w = 0; w < DEPTH; w += 2) begin
      put(w % N, 0, w, 0, 0, 0, 0);
      drain();
    end
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule